// File: doc/BRIEF.md
# Nibble-Loaded Operand Register Pair

This block assembles two byte-wide operands for an arithmetic unit when only a narrow data port is available. Each clock edge can write one four-bit nibble of input data into one half of one of the two operand registers. A two-bit select code chooses both the operand and the half. An active-low load enable must be low for any write to happen; while it is high, both registers hold.

Both complete operands leave the block as parallel registered outputs, so the downstream arithmetic logic always sees the current operand pair. The result path of that arithmetic unit does not pass through this block. The clock may be a slow, hand-pulsed strobe: state changes only on rising edges, and nothing depends on a free-running clock.

Top module: `nib_operand_pair`

## Requirements
- R1: When `rst` is high at a rising edge, both `op_a` and `op_b` read 0x00 after that edge, whatever `load_n`, `sel` and `din` are.
- R2: When `load_n` is 1 at a rising edge (and `rst` is low), `op_a` and `op_b` keep their values for every `sel` and `din`.
- R3: With `load_n` = 0 and `sel` = 2'b00, the edge copies `din` into `op_a[3:0]`.
- R4: With `load_n` = 0 and `sel` = 2'b01, the edge copies `din` into `op_a[7:4]`.
- R5: With `load_n` = 0 and `sel` = 2'b10, the edge copies `din` into `op_b[3:0]`.
- R6: With `load_n` = 0 and `sel` = 2'b11, the edge copies `din` into `op_b[7:4]`.
- R7: A write changes exactly one nibble. The other nibble of the same operand and all of the other operand keep their values.
- R8: The outputs are registered. A write is visible after its edge, and changes on `load_n`, `sel` or `din` between edges do not alter `op_a` or `op_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; may be a manual strobe |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low write enable; 1 holds both registers |
| sel | input | 2 | Bit 1 selects the operand (0 = A, 1 = B); bit 0 selects the half (0 = low, 1 = high) |
| din | input | 4 | Nibble to write |
| op_a | output | 8 | Operand A, {high nibble, low nibble} |
| op_b | output | 8 | Operand B, {high nibble, low nibble} |

## Verification
A wrong decode or a stuck lane shows on `op_a` or `op_b` right after the edge that should have written it or held it. A misrouted nibble corrupts a different byte position from the one selected, and the scoreboard compares both full operands after every edge, so the error is caught on that same edge. Checks taken in the middle of a cycle, after the inputs are changed, would expose any output that was not registered.

// File: rtl/nop_pkg.sv
package nop_pkg;
  // Number of operand registers and nibble lanes in each one.
  localparam int unsigned NUM_OPS     = 2;
  localparam int unsigned NIBS_PER_OP = 2;
  localparam int unsigned NUM_SLOTS   = NUM_OPS * NIBS_PER_OP;
  localparam int unsigned SEL_W       = $clog2(NUM_SLOTS);

  // Slot code: upper bit is the operand, lower bit is the half.
  typedef enum logic [SEL_W-1:0] {
    SLOT_A_LO = 2'b00,
    SLOT_A_HI = 2'b01,
    SLOT_B_LO = 2'b10,
    SLOT_B_HI = 2'b11
  } nib_slot_e;
endpackage

// File: rtl/nop_slot_decode.sv
module nop_slot_decode
  import nop_pkg::*;
(
  input  logic                 load_n,
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_SLOTS-1:0] wr_en
);
  // One write strobe per nibble slot, active only while loading is enabled.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign wr_en[s] = !load_n && (sel == SEL_W'(s));
  end
endmodule

// File: rtl/nop_nibble_lane.sv
module nop_nibble_lane #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [NIB_W-1:0] d,
  output logic [NIB_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  // R3
  lane_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(d)));

  // R7
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/nop_operand_reg.sv
module nop_operand_reg
  import nop_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned OP_W = NIB_W * NIBS_PER_OP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NIBS_PER_OP-1:0] nib_we,
  input  logic [NIB_W-1:0]       din,
  output logic [OP_W-1:0]        value
);
  // Lane 0 is the low nibble, the highest lane the high nibble.
  for (genvar n = 0; n < NIBS_PER_OP; n++) begin : g_lane
    nop_nibble_lane #(.NIB_W(NIB_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .we  (nib_we[n]),
      .d   (din),
      .q   (value[n*NIB_W +: NIB_W])
    );
  end
endmodule

// File: rtl/nib_operand_pair.sv
module nib_operand_pair
  import nop_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned OP_W = NIB_W * NIBS_PER_OP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [NIB_W-1:0] din,
  output logic [OP_W-1:0]  op_a,
  output logic [OP_W-1:0]  op_b
);
  logic [NUM_SLOTS-1:0] wr_en;
  logic [OP_W-1:0]      ops [NUM_OPS];

  nop_slot_decode u_dec (
    .load_n (load_n),
    .sel    (sel),
    .wr_en  (wr_en)
  );

  // Slot index = operand * NIBS_PER_OP + half, matching the select code.
  for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
    nop_operand_reg #(.NIB_W(NIB_W)) u_op (
      .clk    (clk),
      .rst    (rst),
      .nib_we (wr_en[o*NIBS_PER_OP +: NIBS_PER_OP]),
      .din    (din),
      .value  (ops[o])
    );
  end

  assign op_a = ops[0];
  assign op_b = ops[1];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (op_a == '0 && op_b == '0));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load_n |=> ($stable(op_a) && $stable(op_b)));

  // R4
  hi_a_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n && sel == SLOT_A_HI) |=>
      (op_a[OP_W-1 -: NIB_W] == $past(din)) && $stable(op_b));

  // R6
  hi_b_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n && sel == SLOT_B_HI) |=>
      (op_b[OP_W-1 -: NIB_W] == $past(din)) && $stable(op_a));
endmodule

// File: tb/nib_operand_pair_tb.sv
`timescale 1ns/100ps
module nib_operand_pair_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [3:0] din = 4'h0;
  logic [7:0] op_a, op_b;

  always #2.5 clk = ~clk;

  nib_operand_pair u_dut (
    .clk(clk), .rst(rst), .load_n(load_n), .sel(sel), .din(din),
    .op_a(op_a), .op_b(op_b)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    int         req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic [7:0] ma = 8'h00;
  logic [7:0] mb = 8'h00;

  // Driver: one edge of stimulus, model update, expected item queued.
  task automatic step(input logic r, input logic ln, input logic [1:0] s,
                      input logic [3:0] d, input int req);
    exp_t e;
    @(negedge clk);
    rst = r; load_n = ln; sel = s; din = d;
    if (r) begin
      ma = 8'h00; mb = 8'h00;
    end else if (!ln) begin
      case (s)
        2'b00: ma[3:0] = d;
        2'b01: ma[7:4] = d;
        2'b10: mb[3:0] = d;
        default: mb[7:4] = d;
      endcase
    end
    e.a = ma; e.b = mb; e.req = req;
    sbq.push_back(e);
  endtask

  // Monitor: compare after every edge that has a queued expectation.
  exp_t got;
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      got = sbq.pop_front();
      checks++;
      if (op_a !== got.a || op_b !== got.b) begin
        errors++;
        $display("FAIL R%0d: op_a=%h op_b=%h expected op_a=%h op_b=%h",
                 got.req, op_a, op_b, got.a, got.b);
      end
    end
  end

  // R8: disturb inputs mid-cycle, outputs must not move before the next edge.
  task automatic midcheck();
    @(posedge clk);
    #1.5;
    load_n = 1'b0; sel = ~sel; din = ~din;
    #0.4;
    checks++;
    if (op_a !== ma || op_b !== mb) begin
      errors++;
      $display("FAIL R8: op_a=%h op_b=%h expected op_a=%h op_b=%h",
               op_a, op_b, ma, mb);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    step(1, 1, 2'b00, 4'h0, 1);         // R1 reset state
    step(0, 0, 2'b00, 4'h5, 3);         // R3 A low
    step(0, 0, 2'b01, 4'hA, 4);         // R4 A high
    midcheck();                          // R8
    step(0, 0, 2'b10, 4'h3, 5);         // R5 B low
    step(0, 0, 2'b11, 4'hC, 6);         // R6 B high -> A=A5 B=C3
    for (int k = 0; k < 4; k++)         // R2 disabled writes on every code
      step(0, 1, 2'(k), 4'hF, 2);
    midcheck();                          // R8
    step(0, 0, 2'b00, 4'h0, 7);         // R7 only A low changes
    step(0, 0, 2'b11, 4'h9, 7);         // R7 only B high changes
    step(0, 0, 2'b01, 4'h6, 7);         // R7
    step(0, 0, 2'b10, 4'hE, 7);         // R7
    for (int k = 0; k < 8; k++)         // R2 long idle with a manual-style gap
      step(0, 1, 2'b01, 4'(k), 2);
    for (int k = 0; k < 48; k++) begin  // R7 mixed pattern
      logic [7:0] rv;
      rv = 8'($urandom);
      step(0, rv[7], rv[5:4], rv[3:0], 7);
      if (k % 8 == 3) midcheck();       // R8
    end
    step(1, 0, 2'b01, 4'hF, 1);         // R1 reset wins over a write
    step(0, 0, 2'b11, 4'h7, 6);         // R6 after reset
    step(0, 1, 2'b00, 4'h0, 2);
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule